// File: doc/BRIEF.md
# Frame-Synchronous Configuration Register File

This block holds the configuration of a frame-based image receiver and gives it a register bus port. Its registers fall into two classes. The shadowed class can be written at any moment. Each shadowed register keeps two copies:

- a pending copy, which software reads back;
- an active copy, which drives the hardware and takes the pending value only when a start-of-frame strobe arrives.

A setting changed in the middle of a frame therefore never disturbs the frame in progress.

The locked class feeds the hardware straight from its only copy. It may change only while the receiver reports that it is idle. A write to a locked register while the busy input is high is dropped. The dropped write sets a sticky error flag, and software clears that flag by writing 1 to it.

The start-of-frame strobe and the busy level come from the frame detection logic, which is outside this block. The bus is a single-cycle write port with a combinational read path on the same address.

The address map is fixed:

| Addresses | Contents |
|---|---|
| 0 to NS-1 | Shadowed registers |
| NS to NS+NL-1 | Locked registers |
| NS+NL | Status register; bit 0 is the error flag |
| Anything above NS+NL | Unmapped |

Top module: `cfgshd_regfile`

## Requirements
- R1: After reset, shadowed register i reads back SHD_RST_BASE+i and drives SHD_RST_BASE+i on its active output. Locked register j drives LCK_RST_BASE+j. The error flag is 0.
- R2: A write to a shadowed register changes its read-back value on the next cycle. Its active output keeps its old value until a start-of-frame strobe.
- R3: A cycle with the start-of-frame strobe high copies every pending shadowed value to its active output, effective on the following cycle.
- R4: When a shadowed write and the strobe fall in the same cycle, the active output of that register takes the value written in that cycle.
- R5: Several writes to one shadowed register between two strobes leave only the last written value, both pending and active after the next strobe.
- R6: Shadowed writes are accepted whatever the level of busy.
- R7: A write to a locked register while busy is low reaches its output on the next cycle, and the same value reads back.
- R8: A write to a locked register while busy is high leaves the register unchanged and sets the error flag. The error flag reads as bit 0 of the status register at address NS+NL.
- R9: The error flag stays set until bit 0 of the status register is written with 1. A write of 0 to that bit leaves the flag set.
- R10: Unmapped addresses read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | AW | Register address for both read and write |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr, combinational |
| sof | input | 1 | Start-of-frame strobe |
| busy | input | 1 | Receiver busy level |
| act_shadow | output | NS*DW | Active shadowed values; register i is in slice [i*DW +: DW] |
| act_locked | output | NL*DW | Locked values; register j is in slice [j*DW +: DW] |
| wr_err | output | 1 | Sticky flag for a dropped locked write |

## Verification
The vector table combines writes, strobes and busy levels in the following patterns, and each pattern separates one pair of behaviours:

- **Write with no strobe.** Shows whether the pending copy and the active copy are distinct.
- **Strobe alone.** Shows whether the transfer happens at all.
- **Write and strobe in the same cycle.** Shows whether the transfer uses the old or the new value.
- **Back-to-back writes.** Show whether the last write wins.
- **Locked writes with busy low and with busy high.** Separate the accepted path from the rejected path.
- **Status writes of 0 and of 1.** Separate a true write-1-to-clear from a plain overwrite.

Directed steps then write to an unmapped address, re-read the whole map, and apply reset again in the middle of the run.

// File: rtl/cfgshd_pkg.sv
package cfgshd_pkg;
    typedef enum logic [1:0] {
        RK_SHADOW = 2'd0,
        RK_LOCKED = 2'd1,
        RK_STATUS = 2'd2,
        RK_NONE   = 2'd3
    } reg_kind_e;
endpackage

// File: rtl/cfgshd_addr_dec.sv
module cfgshd_addr_dec
    import cfgshd_pkg::*;
#(
    parameter int NS  = 4,
    parameter int NL  = 2,
    parameter int AW  = 3,
    parameter int SIW = 2,
    parameter int LIW = 1
) (
    input  logic [AW-1:0]  addr,
    output reg_kind_e      kind,
    output logic [SIW-1:0] s_idx,
    output logic [LIW-1:0] l_idx
);
    localparam logic [AW-1:0] LBASE = AW'(NS);
    localparam logic [AW-1:0] SADDR = AW'(NS + NL);

    logic [AW-1:0] l_off;

    always_comb begin
        l_off = addr - LBASE;
        s_idx = addr[SIW-1:0];
        l_idx = l_off[LIW-1:0];
        if (addr < LBASE)      kind = RK_SHADOW;
        else if (addr < SADDR) kind = RK_LOCKED;
        else if (addr == SADDR) kind = RK_STATUS;
        else                   kind = RK_NONE;
    end
endmodule

// File: rtl/cfgshd_shadow_bank.sv
module cfgshd_shadow_bank #(
    parameter int          NS       = 4,
    parameter int          DW       = 32,
    parameter int          SIW      = 2,
    parameter logic [31:0] RST_BASE = 32'h100
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [SIW-1:0]         wr_idx,
    input  logic [DW-1:0]          wdata,
    input  logic                   sof,
    output logic [NS-1:0][DW-1:0]  pend,
    output logic [NS-1:0][DW-1:0]  act
);
    typedef struct packed {
        logic [NS-1:0][DW-1:0] pend;
        logic [NS-1:0][DW-1:0] act;
    } shd_state_t;

    shd_state_t            st_d, st_q;
    logic [NS-1:0][DW-1:0] rst_img;

    for (genvar gi = 0; gi < NS; gi++) begin : g_rst
        assign rst_img[gi] = DW'(RST_BASE + 32'(gi));
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.pend[wr_idx] = wdata;
        // The strobe copies the already-updated pending image, so a write in the strobe cycle wins.
        if (sof) st_d.act = st_d.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend <= rst_img;
            st_q.act  <= rst_img;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;
    assign act  = st_q.act;
endmodule

// File: rtl/cfgshd_lock_bank.sv
module cfgshd_lock_bank #(
    parameter int          NL       = 2,
    parameter int          DW       = 32,
    parameter int          LIW      = 1,
    parameter logic [31:0] RST_BASE = 32'h200
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [LIW-1:0]         wr_idx,
    input  logic [DW-1:0]          wdata,
    input  logic                   busy,
    input  logic                   clr_en,
    output logic [NL-1:0][DW-1:0]  vals,
    output logic                   err
);
    typedef struct packed {
        logic [NL-1:0][DW-1:0] vals;
        logic                  err;
    } lck_state_t;

    lck_state_t            st_d, st_q;
    logic [NL-1:0][DW-1:0] rst_img;

    for (genvar gj = 0; gj < NL; gj++) begin : g_rst
        assign rst_img[gj] = DW'(RST_BASE + 32'(gj));
    end

    always_comb begin
        st_d = st_q;
        if (clr_en) st_d.err = 1'b0;
        if (wr_en) begin
            if (busy) st_d.err = 1'b1;
            else      st_d.vals[wr_idx] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.vals <= rst_img;
            st_q.err  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vals = st_q.vals;
    assign err  = st_q.err;
endmodule

// File: rtl/cfgshd_regfile.sv
module cfgshd_regfile
    import cfgshd_pkg::*;
#(
    parameter int          NS           = 4,
    parameter int          NL           = 2,
    parameter int          DW           = 32,
    parameter logic [31:0] SHD_RST_BASE = 32'h100,
    parameter logic [31:0] LCK_RST_BASE = 32'h200,
    parameter int          AW           = $clog2(NS + NL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic             sof,
    input  logic             busy,
    output logic [NS*DW-1:0] act_shadow,
    output logic [NL*DW-1:0] act_locked,
    output logic             wr_err
);
    localparam int SIW = (NS > 1) ? $clog2(NS) : 1;
    localparam int LIW = (NL > 1) ? $clog2(NL) : 1;

    reg_kind_e             kind;
    logic [SIW-1:0]        s_idx;
    logic [LIW-1:0]        l_idx;
    logic [NS-1:0][DW-1:0] pend_img;
    logic [NS-1:0][DW-1:0] act_img;
    logic [NL-1:0][DW-1:0] lck_img;
    logic                  shd_wr, lck_wr, clr_wr;

    cfgshd_addr_dec #(.NS(NS), .NL(NL), .AW(AW), .SIW(SIW), .LIW(LIW)) u_dec (
        .addr (bus_addr),
        .kind (kind),
        .s_idx(s_idx),
        .l_idx(l_idx)
    );

    assign shd_wr = bus_wr && (kind == RK_SHADOW);
    assign lck_wr = bus_wr && (kind == RK_LOCKED);
    assign clr_wr = bus_wr && (kind == RK_STATUS) && bus_wdata[0];

    cfgshd_shadow_bank #(.NS(NS), .DW(DW), .SIW(SIW), .RST_BASE(SHD_RST_BASE)) u_shd (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (shd_wr),
        .wr_idx(s_idx),
        .wdata (bus_wdata),
        .sof   (sof),
        .pend  (pend_img),
        .act   (act_img)
    );

    cfgshd_lock_bank #(.NL(NL), .DW(DW), .LIW(LIW), .RST_BASE(LCK_RST_BASE)) u_lck (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (lck_wr),
        .wr_idx(l_idx),
        .wdata (bus_wdata),
        .busy  (busy),
        .clr_en(clr_wr),
        .vals  (lck_img),
        .err   (wr_err)
    );

    always_comb begin
        unique case (kind)
            RK_SHADOW: bus_rdata = pend_img[s_idx];
            RK_LOCKED: bus_rdata = lck_img[l_idx];
            RK_STATUS: bus_rdata = {{(DW-1){1'b0}}, wr_err};
            default:   bus_rdata = '0;
        endcase
    end

    assign act_shadow = act_img;
    assign act_locked = lck_img;
endmodule

// File: rtl/cfgshd_regfile_chk.sv
module cfgshd_regfile_chk #(
    parameter int NS = 4,
    parameter int NL = 2,
    parameter int DW = 32,
    parameter int AW = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [AW-1:0]    bus_addr,
    input logic [DW-1:0]    bus_wdata,
    input logic             sof,
    input logic             busy,
    input logic [NS*DW-1:0] act_shadow,
    input logic [NL*DW-1:0] act_locked,
    input logic             wr_err,
    input logic [NS*DW-1:0] pend
);
    logic lck_hit, clr_hit;
    assign lck_hit = bus_wr && (int'(bus_addr) >= NS) && (int'(bus_addr) < NS + NL);
    assign clr_hit = bus_wr && (int'(bus_addr) == NS + NL) && bus_wdata[0];

    // R2
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sof |=> $stable(act_shadow));

    // R3
    sof_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> (act_shadow == pend));

    // R8
    lock_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lck_hit && busy) |=> ($stable(act_locked) && wr_err));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_err && !clr_hit) |=> wr_err);
endmodule

bind cfgshd_regfile cfgshd_regfile_chk #(.NS(NS), .NL(NL), .DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .sof       (sof),
    .busy      (busy),
    .act_shadow(act_shadow),
    .act_locked(act_locked),
    .wr_err    (wr_err),
    .pend      (pend_img)
);

// File: tb/cfgshd_regfile_bench.sv
module cfgshd_regfile_bench;
    localparam int NS = 4;
    localparam int NL = 2;
    localparam int DW = 32;
    localparam int AW = 3;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             bus_wr;
    logic [AW-1:0]    bus_addr;
    logic [DW-1:0]    bus_wdata;
    logic [DW-1:0]    bus_rdata;
    logic             sof;
    logic             busy;
    logic [NS*DW-1:0] act_shadow;
    logic [NL*DW-1:0] act_locked;
    logic             wr_err;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    cfgshd_regfile u_cfgshd_regfile (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sof(sof), .busy(busy),
        .act_shadow(act_shadow), .act_locked(act_locked), .wr_err(wr_err)
    );

    typedef struct packed {
        logic        wr;
        logic        sof;
        logic        busy;
        logic [2:0]  addr;
        logic [31:0] wdata;
        logic [2:0]  ridx;
        logic [31:0] exp_rd;
        logic [31:0] exp_act;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 1'b0, 3'd0, 32'hAAAA, 3'd0, 32'hAAAA, 32'h100,  8'd2 },  // R2
        '{1'b1, 1'b0, 1'b1, 3'd0, 32'hBBBB, 3'd0, 32'hBBBB, 32'h100,  8'd5 },  // R5, R6
        '{1'b0, 1'b1, 1'b0, 3'd0, 32'h0,    3'd0, 32'hBBBB, 32'hBBBB, 8'd3 },  // R3
        '{1'b1, 1'b1, 1'b1, 3'd1, 32'h1111, 3'd1, 32'h1111, 32'h1111, 8'd4 },  // R4
        '{1'b1, 1'b0, 1'b0, 3'd4, 32'hCAFE, 3'd4, 32'hCAFE, 32'hCAFE, 8'd7 },  // R7
        '{1'b1, 1'b0, 1'b1, 3'd5, 32'hDEAD, 3'd5, 32'h201,  32'h201,  8'd8 },  // R8
        '{1'b0, 1'b0, 1'b0, 3'd0, 32'h0,    3'd6, 32'h1,    32'h1,    8'd8 },  // R8
        '{1'b1, 1'b0, 1'b0, 3'd6, 32'h0,    3'd6, 32'h1,    32'h1,    8'd9 },  // R9
        '{1'b1, 1'b0, 1'b0, 3'd6, 32'h1,    3'd6, 32'h0,    32'h0,    8'd9 },  // R9
        '{1'b1, 1'b0, 1'b0, 3'd7, 32'hFFFF, 3'd7, 32'h0,    32'h0,    8'd10},  // R10
        '{1'b1, 1'b0, 1'b0, 3'd2, 32'h2222, 3'd2, 32'h2222, 32'h102,  8'd2 },  // R2
        '{1'b0, 1'b1, 1'b1, 3'd0, 32'h0,    3'd2, 32'h2222, 32'h2222, 8'd3 }   // R3
    };

    function automatic logic [31:0] get_act(input int idx);
        if (idx < NS)           return act_shadow[idx*DW +: DW];
        else if (idx < NS + NL) return act_locked[(idx-NS)*DW +: DW];
        else if (idx == NS + NL) return {31'b0, wr_err};
        else                    return 32'h0;
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic read_chk(input string req, input int idx, input logic [31:0] rd, input logic [31:0] av);
        bus_addr = AW'(idx);
        #1;
        check(req, $sformatf("rdata[%0d]", idx), bus_rdata, rd);
        check(req, $sformatf("active[%0d]", idx), get_act(idx), av);
    endtask

    task automatic reset_chk();
        for (int i = 0; i < NS; i++) read_chk("R1", i, 32'h100 + 32'(i), 32'h100 + 32'(i));
        for (int j = 0; j < NL; j++) read_chk("R1", NS + j, 32'h200 + 32'(j), 32'h200 + 32'(j));
        read_chk("R1", NS + NL, 32'h0, 32'h0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; sof = 1'b0; busy = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        reset_chk();

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            bus_wr = VEC[v].wr; sof = VEC[v].sof; busy = VEC[v].busy;
            bus_addr = VEC[v].addr; bus_wdata = VEC[v].wdata;
            @(posedge clk);
            #1;
            bus_wr = 1'b0; sof = 1'b0; busy = 1'b0;
            read_chk($sformatf("R%0d", VEC[v].req), int'(VEC[v].ridx), VEC[v].exp_rd, VEC[v].exp_act);
        end

        // R10: the write to the unmapped address left every register as before
        read_chk("R10", 0, 32'hBBBB, 32'hBBBB);
        read_chk("R10", 1, 32'h1111, 32'h1111);
        read_chk("R10", 3, 32'h103,  32'h103);
        read_chk("R10", 5, 32'h201,  32'h201);

        // R4 and R6: a busy write in the strobe cycle, then a second strobe keeps that value
        @(negedge clk);
        bus_wr = 1'b1; sof = 1'b1; busy = 1'b1; bus_addr = 3'd3; bus_wdata = 32'h3333;
        @(posedge clk); #1; bus_wr = 1'b0; busy = 1'b0;
        @(posedge clk); #1; sof = 1'b0;
        read_chk("R4", 3, 32'h3333, 32'h3333);

        // R1: reset applied again in the middle of the run
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        reset_chk();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule